// File: doc/BRIEF.md
# SPI Single-Register Access Master

This block lets on-chip logic read or write one 8-bit register of an external USB host controller over a full-duplex, four-wire SPI link. A request names a 5-bit register number, a direction and a write byte. The block lowers the chip select, clocks out a command byte and then a data byte, and raises the select again. It returns two bytes: the one shifted in during the command byte, which is the controller's status, and the one shifted in during the data byte, which is the read data.

The requester pulses `start_i` while `busy_o` is low and waits for the single-cycle `done_o`. The SCLK half period is set by `half_div_i` and captured when the request is accepted. After each transaction the select stays high for at least one half period before the next one can begin.

Top module: `spi_reg_master`

## Requirements
- R1: The first byte sent is the command: register number in bits 7:3, bit 1 set for a write and clear for a read, bits 2 and 0 zero.
- R2: The second byte sent is `wdata_i` for a write and 0x00 for a read. Both bytes are taken when the request is accepted, so later changes on the request inputs have no effect.
- R3: Bits go out and come in most significant bit first.
- R4: MOSI changes only while SCLK is low. MISO is sampled in the last system cycle of each SCLK high phase. SCLK is low whenever the select is high.
- R5: `status_o` holds the byte received during the command byte. `rdata_o` holds the byte received during the second byte. Both are valid in the cycle `done_o` is high and keep their values until the next transaction ends.
- R6: While in reset and when idle, `ss_no` is high and `sclk_o` and `mosi_o` are low.
- R7: Each select-low window contains exactly 16 SCLK rising edges.
- R8: `start_i` is accepted only while `busy_o` is low. A start during a transaction is ignored.
- R9: `done_o` is a one-cycle pulse. It rises 32 half periods after the accepting edge, in the same cycle the select returns high.
- R10: Each SCLK high phase and each SCLK low phase lasts `half_div_i`+1 system cycles, using the value captured at acceptance.
- R11: Between two transactions the select stays high for at least one half period. With `start_i` held high, the gap is exactly `half_div_i`+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| wr_i | input | 1 | 1 = register write, 0 = register read |
| reg_i | input | 5 | Register number |
| wdata_i | input | 8 | Byte to write |
| half_div_i | input | 8 | SCLK half period minus one, in system cycles |
| busy_o | output | 1 | Transaction or deselect gap in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Byte received during the command byte |
| rdata_o | output | 8 | Byte received during the data byte |
| ss_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the controller |
| miso_i | input | 1 | Serial data from the controller |

## Verification
Two events can fall in the same cycle: completion of one transaction and a new request arriving. A request can also arrive in the middle of a transaction. The bench holds `start_i` high across `done_o`. It then checks that the select stays high for exactly `half_div_i`+2 cycles and that the second frame carries its own command. It also pulses a start with a different register partway through a frame, and checks that only one frame with the original command reaches the modelled controller.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_reg_tick.sv
module spi_reg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || tick_o)     cnt_q <= '0;
    else if (run_i)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_reg_shift.sv
module spi_reg_shift #(
  parameter int REG_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int FRAME_W = 2 * BYTE_W;

  logic [FRAME_W-1:0] tx_q, rx_q, rx_nxt;
  logic [BYTE_W-1:0]  cmd, dat, status_q, rdata_q;

  // register number in the top bits, direction flag in bit 1
  always_comb begin
    cmd = '0;
    cmd[BYTE_W-1 -: REG_W] = reg_i;
    cmd[1] = wr_i;
    dat = wr_i ? wdata_i : '0;
  end

  assign rx_nxt = {rx_q[FRAME_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= {cmd, dat};
      rx_q <= '0;
    end else if (shift_i) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      rx_q <= rx_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      rdata_q  <= '0;
    end else if (cap_i) begin
      status_q <= rx_nxt[FRAME_W-1:BYTE_W];
      rdata_q  <= rx_nxt[BYTE_W-1:0];
    end
  end

  assign mosi_o   = tx_q[FRAME_W-1];
  assign status_o = status_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DIV_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             cap_o,
  output logic             clr_o,
  output logic             run_o,
  output logic [DIV_W-1:0] limit_o,
  output logic             sclk_o,
  output logic             ss_no,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_q;
  logic             sclk_q, ss_q, done_q;
  logic             accept, last;

  assign accept  = (ph_q == PH_IDLE) && start_i;
  assign last    = (bit_q == LAST_BIT);
  assign shift_o = (ph_q == PH_HIGH) && tick_i;
  assign cap_o   = shift_o && last;
  assign load_o  = accept;
  assign clr_o   = accept;
  assign run_o   = (ph_q != PH_IDLE);
  assign limit_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_LOW;
          div_q <= half_div_i;
          bit_q <= '0;
          ss_q  <= 1'b0;
        end
        PH_LOW: if (tick_i) begin
          ph_q   <= PH_HIGH;
          sclk_q <= 1'b1;
        end
        PH_HIGH: if (tick_i) begin
          sclk_q <= 1'b0;
          bit_q  <= bit_q + 1'b1;
          if (last) begin
            ph_q   <= PH_GAP;
            ss_q   <= 1'b1;
            done_q <= 1'b1;
          end else begin
            ph_q <= PH_LOW;
          end
        end
        PH_GAP: if (tick_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign ss_no  = ss_q;
  assign busy_o = run_o;
  assign done_o = done_q;
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int REG_W  = 5,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  half_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ss_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int FRAME_W = 2 * BYTE_W;

  logic             load, shift, cap, clr, run, tick;
  logic [DIV_W-1:0] limit;

  spi_reg_ctrl #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .half_div_i,
    .tick_i(tick), .load_o(load), .shift_o(shift), .cap_o(cap),
    .clr_o(clr), .run_o(run), .limit_o(limit),
    .sclk_o, .ss_no, .busy_o, .done_o
  );

  spi_reg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(run), .limit_i(limit), .tick_o(tick)
  );

  spi_reg_shift #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .wr_i, .reg_i, .wdata_i,
    .shift_i(shift), .cap_i(cap), .miso_i,
    .mosi_o, .status_o, .rdata_o
  );
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic ss_no,
  input logic sclk_o,
  input logic mosi_o
);
  logic [5:0] rise_cnt;
  logic [3:0] gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0;
      gap_cnt  <= 4'hF;
    end else begin
      if (ss_no) rise_cnt <= '0;
      else if (sclk_o && !$past(sclk_o) && rise_cnt != 6'h3F) rise_cnt <= rise_cnt + 1'b1;
      if (!ss_no) gap_cnt <= '0;
      else if (gap_cnt != 4'hF) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_idle_lines_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> (!sclk_o && !mosi_o));
  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_deselect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ss_no);
  p_idle_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ss_no);
  p_edge_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> (rise_cnt == 6'd16));
  p_gap_min_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> (gap_cnt >= 4'd1));
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .ss_no, .sclk_o, .mosi_o
);

// File: tb/spi_reg_master_bench.sv
`timescale 1ns/1ps
module spi_reg_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr = 1'b0;
  logic [4:0] rnum = '0;
  logic [7:0] wdata = '0, hdiv = '0;
  logic       busy, done, ss_n, sclk, mosi, miso;
  logic [7:0] status, rdata;

  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  spi_reg_master u_spi_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .reg_i(rnum),
    .wdata_i(wdata), .half_div_i(hdiv), .busy_o(busy), .done_o(done),
    .status_o(status), .rdata_o(rdata), .ss_no(ss_n), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  // modelled controller: MISO shifts on SCLK fall, MOSI captured on SCLK rise
  logic [15:0] resp = '0, resp_q = '0, rx_s = '0, last_frame = '0;
  int fall_cnt = 0, fall_base = 0, rises = 0, rise_base = 0;
  int frames = 0, last_rises = 0;
  int nb;

  always @(negedge sclk) fall_cnt = fall_cnt + 1;
  always @(posedge sclk) begin rx_s = {rx_s[14:0], mosi}; rises = rises + 1; end
  always @(negedge ss_n) begin fall_base = fall_cnt; rise_base = rises; resp_q = resp; end
  always @(posedge ss_n) if (rst_n) begin
    last_frame = rx_s; last_rises = rises - rise_base; frames = frames + 1;
  end
  assign nb   = fall_cnt - fall_base;
  assign miso = (nb >= 0 && nb < 16) ? resp_q[15 - nb] : 1'b0;

  // SCLK high-phase length monitor
  int exp_h = 1, hi_run = 0, hi_bad = 0;
  always @(posedge clk) begin
    if (sclk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run != exp_h) hi_bad = hi_bad + 1;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [4:0] r, input logic [7:0] d, input int h);
    @(negedge clk);
    start = 1'b1; wr = w; rnum = r; wdata = d; hdiv = 8'(h - 1);
    @(negedge clk);
    start = 1'b0; wr = ~w; rnum = ~r; wdata = ~d;  // must not matter after acceptance
  endtask

  task automatic run_txn(input logic w, input logic [4:0] r, input logic [7:0] d,
                         input logic [7:0] st, input logic [7:0] rd, input int h);
    int n, f0;
    logic [7:0] ecmd, edat;
    ecmd = {r, 1'b0, w, 1'b0};
    edat = w ? d : 8'h00;
    resp = {st, rd}; exp_h = h; hi_bad = 0; f0 = frames;
    issue(w, r, d, h);
    n = 1;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(n == 32*h + 1, "R9", "done latency", 32'(n), 32'(32*h + 1));
    chk(status == st, "R5", "status byte", 32'(status), 32'(st));
    chk(rdata == rd, "R5", "read byte", 32'(rdata), 32'(rd));
    chk(frames == f0 + 1, "R7", "frame count", 32'(frames), 32'(f0 + 1));
    chk(last_frame[15:8] == ecmd, "R1 R3", "command byte", 32'(last_frame[15:8]), 32'(ecmd));
    chk(last_frame[7:0] == edat, "R2", "data byte", 32'(last_frame[7:0]), 32'(edat));
    chk(last_rises == 16, "R7", "sclk rises", 32'(last_rises), 32'd16);
    chk(hi_bad == 0, "R10", "high phase length", 32'(hi_bad), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 32'(done), 32'd0);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int f0, n, cnt;
    #35;
    chk(ss_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R6", "lines in reset",
        32'({ss_n, sclk, mosi}), 32'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ss_n && !sclk && !mosi && !busy && !done, "R6", "idle lines",
        32'({ss_n, sclk, mosi, busy, done}), 32'b10000);

    // sweep every register in both directions across three dividers
    for (int r = 0; r < 32; r++) begin
      for (int w = 0; w < 2; w++) begin
        run_txn(w[0], 5'(r), 8'(r*29 + 3), 8'(r*7 + w) ^ 8'hA5, ~8'(r*13 + w), 1 + ((r + w) % 3));
      end
    end

    // R8: a start in mid-transaction is ignored
    resp = 16'h3C5A; exp_h = 2; f0 = frames;
    issue(1'b0, 5'd9, 8'h00, 2);
    repeat (20) @(negedge clk);
    start = 1'b1; rnum = 5'd22; wr = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(last_frame[15:8] == 8'h48, "R8", "command kept", 32'(last_frame[15:8]), 32'h48);
    cnt = 0;
    repeat (200) begin @(negedge clk); if (!ss_n) cnt++; end
    chk(frames == f0 + 1 && cnt == 0, "R8", "extra frames", 32'(frames - f0), 32'd1);

    // R11: start held high across completion
    resp = 16'h9E17; exp_h = 3;
    @(negedge clk);
    start = 1'b1; wr = 1'b1; rnum = 5'd5; wdata = 8'hC3; hdiv = 8'd2;
    while (!done) @(negedge clk);
    rnum = 5'd30; wr = 1'b0;
    n = 0;
    while (ss_n && n < 100) begin @(negedge clk); n++; end
    chk(n == 4, "R11", "deselect gap", 32'(n), 32'd4);
    chk(last_frame == 16'h2AC3, "R11", "first frame", 32'(last_frame), 32'h2AC3);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(last_frame == 16'hF000, "R11", "second frame", 32'(last_frame), 32'hF000);
    chk(status == 8'h9E && rdata == 8'h17, "R5", "second result",
        32'({status, rdata}), 32'h9E17);
    while (busy) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule